// File: doc/BRIEF.md
# Serial Bus Master Interrupt Status and Enable Registers

This block collects single-cycle event pulses from a serial bus master's protocol engine and holds each one in a 16-bit status register until software clears it. Software reads and writes three 16-bit registers over a simple register bus: the status word, an interrupt-enable word and a wakeup-enable word. To clear a status bit, software writes a 1 to it. The block drives a level interrupt whenever a set status bit has its interrupt enable set. It drives a wakeup level whenever a set status bit has its wakeup enable set.

Bit 12 of the status word is not stored. It reflects the bus-busy level from the protocol engine and is always live, so software can poll it before it starts a transfer. The ready and drain bits behave like the other event bits and stay set until software clears them, which it does after it has moved the data.

Top module: `evt_irq_regs`

## Requirements
- R1: After reset the status, interrupt-enable and wakeup-enable registers read zero, and `irq_o` and `wake_o` are low.
- R2: An event pulse on `evt_in` bit 14, 13, 11, 10, 9, 8, 4, 3, 2, 1 or 0 sets the status bit at the same position on the next clock edge. Status is at register index 0.
- R3: A write to index 0 clears every status bit written as 1 and leaves every bit written as 0 unchanged, so one write can clear some bits and keep others pending.
- R4: When an event pulse and a clear for the same bit fall in the same cycle, the bit stays set.
- R5: Status bit 12 reads `bus_busy_in` directly. Writes to it have no effect, and `evt_in[12]` is ignored.
- R6: The interrupt-enable register is at index 1. Bits 14, 13, 4, 3, 2, 1 and 0 are writable and all other bits read zero.
- R7: The wakeup-enable register is at index 2. Bits 14, 13, 9, 8, 6, 5, 3, 2, 1 and 0 are writable and all other bits read zero.
- R8: `irq_o` is registered. It goes high one clock after a status bit and its interrupt enable are both set, and low one clock after no such pair remains.
- R9: Writing zero to the interrupt-enable register drops `irq_o` one clock after the enable changes, and the status bits are unchanged.
- R10: `wake_o` goes high one clock after a set status bit has its wakeup enable set, whatever the interrupt enable holds.
- R11: Status bits 15, 7, 6 and 5 always read zero, and event pulses on those positions are ignored.
- R12: Index 3 reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 16 | Event pulses from the protocol engine, one per status position |
| bus_busy_in | input | 1 | Bus-busy level from the protocol engine |
| reg_addr | input | 2 | Register index (0 status, 1 interrupt enable, 2 wakeup enable) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Level interrupt |
| wake_o | output | 1 | Wakeup request |

## Verification
The bench drives an event and a clear for the same bit in the same cycle. A design that gave the clear priority would lose that event, and the status read would miss the bit. It also clears some bits while leaving others pending, which exposes a design that treats a written 0 as a clear. The bench checks the interrupt in both the cycle before it is due and the cycle in which it is due, so an unregistered interrupt, or one delayed by an extra stage, is reported. Bus busy is toggled live and written with a 1: a design that latched bit 12 or let a write clear it would read back the wrong level.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int REG_W = 16;
  localparam int IDX_W = 2;

  // Status bit positions (software decodes these)
  localparam int B_TXDRAIN = 14;
  localparam int B_RXDRAIN = 13;
  localparam int B_BUSY    = 12;
  localparam int B_RXOVR   = 11;
  localparam int B_TXUND   = 10;
  localparam int B_TGTADR  = 9;
  localparam int B_ADRZERO = 8;
  localparam int B_TXRDY   = 4;
  localparam int B_RXRDY   = 3;
  localparam int B_ACCRDY  = 2;
  localparam int B_NOACK   = 1;
  localparam int B_ARBLOST = 0;
  // Wakeup-only positions
  localparam int W_BUSFREE = 8;
  localparam int W_START   = 6;
  localparam int W_GENCALL = 5;
  localparam int W_DATARDY = 3;

  localparam logic [REG_W-1:0] ONE = REG_W'(1);

  localparam logic [REG_W-1:0] EVT_MASK =
    (ONE << B_TXDRAIN) | (ONE << B_RXDRAIN) | (ONE << B_RXOVR) |
    (ONE << B_TXUND) | (ONE << B_TGTADR) | (ONE << B_ADRZERO) |
    (ONE << B_TXRDY) | (ONE << B_RXRDY) | (ONE << B_ACCRDY) |
    (ONE << B_NOACK) | (ONE << B_ARBLOST);

  localparam logic [REG_W-1:0] IEN_MASK =
    (ONE << B_TXDRAIN) | (ONE << B_RXDRAIN) | (ONE << B_TXRDY) |
    (ONE << B_RXRDY) | (ONE << B_ACCRDY) | (ONE << B_NOACK) |
    (ONE << B_ARBLOST);

  localparam logic [REG_W-1:0] WEN_MASK =
    (ONE << B_TXDRAIN) | (ONE << B_RXDRAIN) | (ONE << B_TGTADR) |
    (ONE << W_BUSFREE) | (ONE << W_START) | (ONE << W_GENCALL) |
    (ONE << W_DATARDY) | (ONE << B_ACCRDY) | (ONE << B_NOACK) |
    (ONE << B_ARBLOST);

  localparam logic [IDX_W-1:0] IDX_STAT = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_IEN  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_WEN  = IDX_W'(2);

  // Any set bit of a that is also set in b
  function automatic logic any_hit(input logic [REG_W-1:0] a,
                                   input logic [REG_W-1:0] b);
    return |(a & b);
  endfunction

  // Merge the live busy level into a stored status word
  function automatic logic [REG_W-1:0] with_busy(input logic [REG_W-1:0] s,
                                                 input logic busy);
    logic [REG_W-1:0] r;
    r = s;
    r[B_BUSY] = busy;
    return r;
  endfunction
endpackage

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import evt_irq_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [W-1:0] KEEP = EVT_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_in,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] stat_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP[i]) begin : g_flop
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= 1'b0;
        else if (evt_in[i])
          q <= 1'b1;              // event has priority over clear
        else if (clr_wr && clr_bits[i])
          q <= 1'b0;
      end
      assign stat_q[i] = q;
    end else begin : g_tie
      assign stat_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/cfg_mask_reg.sv
module cfg_mask_reg
  import evt_irq_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [W-1:0] KEEP = IEN_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP[i]) begin : g_flop
      logic b;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b <= 1'b0;
        else if (wr) b <= wdata[i];
      end
      assign q[i] = b;
    end else begin : g_tie
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_fold.sv
module irq_fold
  import evt_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] stat,
  input  logic [REG_W-1:0] ien,
  input  logic [REG_W-1:0] wen,
  output logic             irq_hit,
  output logic             wake_hit,
  output logic             irq_o,
  output logic             wake_o
);
  assign irq_hit  = any_hit(stat, ien);
  assign wake_hit = any_hit(stat, wen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= irq_hit;
      wake_o <= wake_hit;
    end
  end
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int W = REG_W,
  parameter int AW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  evt_in,
  input  logic          bus_busy_in,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic          irq_o,
  output logic          wake_o
);
  logic         stat_wr, ien_wr, wen_wr;
  logic [W-1:0] stat_q, ien_q, wen_q;
  logic         irq_hit, wake_hit;

  assign stat_wr = reg_wr && (reg_addr == AW'(IDX_STAT));
  assign ien_wr  = reg_wr && (reg_addr == AW'(IDX_IEN));
  assign wen_wr  = reg_wr && (reg_addr == AW'(IDX_WEN));

  evt_status_reg #(.W(W), .KEEP(EVT_MASK)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
    .clr_wr(stat_wr), .clr_bits(reg_wdata), .stat_q(stat_q)
  );

  cfg_mask_reg #(.W(W), .KEEP(IEN_MASK)) u_ien (
    .clk(clk), .rst_n(rst_n), .wr(ien_wr), .wdata(reg_wdata), .q(ien_q)
  );

  cfg_mask_reg #(.W(W), .KEEP(WEN_MASK)) u_wen (
    .clk(clk), .rst_n(rst_n), .wr(wen_wr), .wdata(reg_wdata), .q(wen_q)
  );

  irq_fold u_fold (
    .clk(clk), .rst_n(rst_n), .stat(stat_q), .ien(ien_q), .wen(wen_q),
    .irq_hit(irq_hit), .wake_hit(wake_hit), .irq_o(irq_o), .wake_o(wake_o)
  );

  always_comb begin
    case (reg_addr)
      AW'(IDX_STAT): reg_rdata = with_busy(stat_q, bus_busy_in);
      AW'(IDX_IEN):  reg_rdata = ien_q;
      AW'(IDX_WEN):  reg_rdata = wen_q;
      default:       reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_regs_chk.sv
module evt_irq_regs_chk
  import evt_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] evt_in,
  input logic             bus_busy_in,
  input logic [IDX_W-1:0] reg_addr,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic [REG_W-1:0] stat_q,
  input logic [REG_W-1:0] ien_q,
  input logic [REG_W-1:0] wen_q,
  input logic             irq_o,
  input logic             wake_o
);
  // R4
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_in & EVT_MASK)) |=>
      ((stat_q & $past(evt_in & EVT_MASK)) == $past(evt_in & EVT_MASK)));

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == IDX_STAT) |=>
      ((stat_q & $past(reg_wdata & ~evt_in)) == '0));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_wr && reg_addr == IDX_STAT) && evt_in == '0) |=> $stable(stat_q));

  // R5
  busy_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == IDX_STAT) |-> (reg_rdata[B_BUSY] == bus_busy_in));

  // R6
  ien_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q & ~IEN_MASK) == '0);

  // R7
  wen_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_q & ~WEN_MASK) == '0);

  // R11
  stat_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~EVT_MASK) == '0);

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & ien_q)) |=> irq_o);

  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_q & ien_q)) |=> !irq_o);

  // R10
  wake_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & wen_q)) |=> wake_o);

  // R12
  idx3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == IDX_W'(3)) |-> (reg_rdata == '0));
endmodule

bind evt_irq_regs evt_irq_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_busy_in(bus_busy_in),
  .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .stat_q(stat_q), .ien_q(ien_q), .wen_q(wen_q),
  .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/tb_evt_irq_regs.sv
`timescale 1ns/1ps
module tb_evt_irq_regs;
  localparam logic [15:0] M_EVT = 16'h6F1F;
  localparam logic [15:0] M_IEN = 16'h601F;
  localparam logic [15:0] M_WEN = 16'h636F;

  // {event, interrupt enable, wakeup enable}
  localparam logic [47:0] VEC [0:5] = '{
    {16'h0001, 16'h0001, 16'h0000},
    {16'h4000, 16'h0010, 16'h4000},
    {16'hFFFF, 16'hFFFF, 16'h0000},
    {16'h0100, 16'hFFFF, 16'h0100},
    {16'h00E0, 16'hFFFF, 16'hFFFF},
    {16'h0808, 16'h0008, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_in = '0;
  logic        bus_busy_in = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_o, wake_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  evt_irq_regs dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_busy_in(bus_busy_in),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic [15:0] got,
                       input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [15:0] e);
    @(negedge clk);
    evt_in = e;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic pulse_and_clear(input logic [15:0] e, input logic [15:0] c);
    @(negedge clk);
    evt_in = e; reg_addr = 2'd0; reg_wdata = c; reg_wr = 1'b1;
    @(negedge clk);
    evt_in = '0; reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [15:0] e, ie, we, es;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 status", v, 16'h0000);
    rd(2'd1, v); check("R1 ien", v, 16'h0000);
    rd(2'd2, v); check("R1 wen", v, 16'h0000);
    check("R1 irq", {15'd0, irq_o}, 16'd0);
    check("R1 wake", {15'd0, wake_o}, 16'd0);

    // Vector table: R2 R8 R10 R11
    for (int k = 0; k < 6; k++) begin
      e = VEC[k][47:32]; ie = VEC[k][31:16]; we = VEC[k][15:0];
      wr(2'd0, 16'hFFFF);
      wr(2'd1, ie);
      wr(2'd2, we);
      pulse(e);
      @(negedge clk);
      es = e & M_EVT;
      rd(2'd0, v); check("R2 R11 status after event", v, es);
      check("R8 irq", {15'd0, irq_o}, {15'd0, |(es & ie & M_IEN)});
      check("R10 wake", {15'd0, wake_o}, {15'd0, |(es & we & M_WEN)});
    end

    // reset enables and status
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0000);
    @(negedge clk);

    // R6 R7 writable masks
    wr(2'd1, 16'hFFFF); rd(2'd1, v); check("R6 ien mask", v, M_IEN);
    wr(2'd2, 16'hFFFF); rd(2'd2, v); check("R7 wen mask", v, M_WEN);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0000);

    // R3 partial clear, zero write keeps
    pulse(16'h0007);
    wr(2'd0, 16'h0005); rd(2'd0, v); check("R3 partial clear", v, 16'h0002);
    wr(2'd0, 16'h0000); rd(2'd0, v); check("R3 zero write keeps", v, 16'h0002);
    wr(2'd0, 16'hFFFF); rd(2'd0, v); check("R3 clear all", v, 16'h0000);

    // R4 event beats clear on the same bit
    pulse(16'h0001);
    pulse_and_clear(16'h0002, 16'h0003);
    rd(2'd0, v); check("R4 event wins", v, 16'h0002);
    wr(2'd0, 16'hFFFF);

    // R5 live busy bit
    bus_busy_in = 1'b1;
    rd(2'd0, v); check("R5 busy high", v, 16'h1000);
    wr(2'd0, 16'h1000); rd(2'd0, v); check("R5 busy not clearable", v, 16'h1000);
    bus_busy_in = 1'b0;
    rd(2'd0, v); check("R5 busy low", v, 16'h0000);
    pulse(16'h1000); rd(2'd0, v); check("R5 busy event ignored", v, 16'h0000);

    // R8 latency then R9 enable drop
    wr(2'd1, 16'h0004);
    pulse(16'h0004);
    check("R8 irq not yet", {15'd0, irq_o}, 16'd0);
    @(negedge clk);
    check("R8 irq one cycle later", {15'd0, irq_o}, 16'd1);
    wr(2'd1, 16'h0000);
    check("R9 irq holds one cycle", {15'd0, irq_o}, 16'd1);
    @(negedge clk);
    check("R9 irq drops", {15'd0, irq_o}, 16'd0);
    rd(2'd0, v); check("R9 status kept", v, 16'h0004);

    // R12 index 3
    wr(2'd1, 16'h0003);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, v); check("R12 idx3 reads zero", v, 16'h0000);
    rd(2'd0, v); check("R12 status untouched", v, 16'h0004);
    rd(2'd1, v); check("R12 ien untouched", v, 16'h0003);
    rd(2'd2, v); check("R12 wen untouched", v, 16'h0000);

    finish_run();
  end
endmodule